// File: doc/BRIEF.md
# Bidirectional Parallel Port with Floating-Bit Retention

This block is an 8-bit bidirectional I/O port that sits on a small processor bus at two register offsets. A direction register sets each pin to output (1) or input (0). A data latch supplies the value for the output pins. Each pin also has a fixed pull-up and pull-down setting, given per instance as parameters.

Reading the data offset returns a mix that is formed bit by bit:
- Output bits return the latch.
- Input bits return the synchronized pin value, ORed with a retention mask. The mask models a floating line that keeps its last level. It is loaded from the data latch whenever the direction register takes a new value.
- Input bits that are pulled down are forced to zero.

The pin drive value is the latch on output bits and the pull-up pattern on input bits. System logic uses it to steer the external lines.

Top module: `bidir_io_port`

## Requirements
- R1: While `rst_n` is low on a rising edge, the registers take these values on that edge: direction 0x00, data latch 0xFF, retention mask 0xFF.
- R2: A write to offset 0 with a value different from the current direction register loads that value. On the same edge it copies the data latch into the retention mask.
- R3: A write to offset 0 with a value equal to the current direction register leaves both the direction register and the retention mask unchanged.
- R4: A write to offset 1 always loads the data latch and never changes the retention mask.
- R5: A read of offset 1 returns `((pins & ~dir) | (mask & ~dir) | (latch & dir)) & ~(PULLDOWN & ~dir)`. `pins` is the synchronized pin input and bit i of `dir` equal to 1 means output.
- R6: A read of offset 0 returns the direction register.
- R7: `pin_out` equals `(latch & dir) | (PULLUP & ~dir)`. It follows any register write on the next cycle.
- R8: `pin_in` passes through a two-flop synchronizer. A change on `pin_in` shows in read data two rising edges later, and not after only one.
- R9: Writes to any offset other than 0 and 1 change no state. Reads of such offsets return 0x00.
- R10: `bus_rdata` is 0x00 whenever `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (2) | Register offset: 0 selects direction, 1 selects data |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_en | input | 1 | Read strobe; gates `bus_rdata` |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Combinational read data |
| pin_in | input | WIDTH (8) | Asynchronous external pin levels |
| pin_out | output | WIDTH (8) | Pin drive value |

## Verification
A register write takes effect on the rising edge that samples it. So both read data and `pin_out` are checked at the falling edge that follows, one cycle after the write is presented. Read data is combinational from the address: the bench sets the offset and read strobe at a falling edge and samples a moment later, within the same half cycle. A pin change reaches read data only after two rising edges. The bench samples once after the first edge, expecting the old value, and again after the second, expecting the new value.

// File: rtl/bidir_io_port_pkg.sv
// Package: shared register-select type for the bidirectional port.
// Assumes only two offsets are mapped; every other offset decodes to SEL_NONE.
package bidir_io_port_pkg;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/bidir_io_sync.sv
// Module: per-bit multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 1. Each stage clears to zero under synchronous active-low reset.
module bidir_io_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pin levels into the first flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            // Shift the value one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/bidir_io_regs.sv
// Module: direction register, data latch and floating-bit retention mask.
// Assumes write strobe and select are stable at the rising edge. The mask is
// loaded from the latch only when the direction register really changes.
module bidir_io_regs
    import bidir_io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] mask_q
);

    logic dir_wr;
    logic dir_change;
    logic latch_wr;

    // Qualify the two write kinds from the decoded select.
    always_comb begin
        dir_wr     = wr_en && (sel == SEL_DIR);
        dir_change = dir_wr && (wdata != dir_q);
        latch_wr   = wr_en && (sel == SEL_DATA);
    end

    // Direction register and retention mask move together on a real change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            mask_q <= '1;
        end else if (dir_change) begin
            dir_q  <= wdata;
            mask_q <= latch_q;
        end
    end

    // The data latch loads on every write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '1;
        else if (latch_wr) latch_q <= wdata;
    end

endmodule

// File: rtl/bidir_io_mix.sv
// Module: read-back mixing and pin drive value.
// Purely combinational. Assumes the pin inputs are already synchronized.
// PULLUP / PULLDOWN are fixed per-bit board settings.
module bidir_io_mix
    import bidir_io_port_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] PULLUP   = '0,
    parameter logic [WIDTH-1:0] PULLDOWN = '0
) (
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] mask_q,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] drive
);

    logic [WIDTH-1:0] in_bits;
    logic [WIDTH-1:0] keep_bits;
    logic [WIDTH-1:0] out_bits;
    logic [WIDTH-1:0] force_low;
    logic [WIDTH-1:0] data_view;

    // Blend pins, retained levels and driven bits; clear pulled-down inputs.
    always_comb begin
        in_bits   = pins_sync & ~dir_q;
        keep_bits = mask_q & ~dir_q;
        out_bits  = latch_q & dir_q;
        force_low = PULLDOWN & ~dir_q;
        data_view = (in_bits | keep_bits | out_bits) & ~force_low;
    end

    // Select the register view for the addressed offset.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_DIR:  rdata = dir_q;
                SEL_DATA: rdata = data_view;
                default:  rdata = '0;
            endcase
        end
    end

    // Drive the latch on outputs and the pull-up pattern on inputs.
    always_comb begin
        drive = (latch_q & dir_q) | (PULLUP & ~dir_q);
    end

endmodule

// File: rtl/bidir_io_port.sv
// Module: top of the bus-mapped bidirectional port.
// Assumes a synchronous single-cycle bus: writes land on the rising edge and
// read data is combinational. Offset 0 is direction, offset 1 is data.
module bidir_io_port
    import bidir_io_port_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter int               ADDR_W      = 2,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] PULLUP      = '0,
    parameter logic [WIDTH-1:0] PULLDOWN    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out
);

    localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(1);

    reg_sel_e         sel;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] mask_q;

    // Decode the offset into a register select.
    always_comb begin
        if (bus_addr == OFS_DIR)       sel = SEL_DIR;
        else if (bus_addr == OFS_DATA) sel = SEL_DATA;
        else                           sel = SEL_NONE;
    end

    bidir_io_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    bidir_io_regs #(
        .WIDTH (WIDTH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .sel     (sel),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .mask_q  (mask_q)
    );

    bidir_io_mix #(
        .WIDTH    (WIDTH),
        .PULLUP   (PULLUP),
        .PULLDOWN (PULLDOWN)
    ) u_mix (
        .rd_en     (bus_rd_en),
        .sel       (sel),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .mask_q    (mask_q),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata),
        .drive     (pin_out)
    );

endmodule

// File: rtl/bidir_io_port_chk.sv
// Module: assertion checker for the bidirectional port, bound to its top.
// Assumes visibility of the three state registers through the bind connections.
module bidir_io_port_chk #(
    parameter int               WIDTH  = 8,
    parameter int               ADDR_W = 2,
    parameter logic [WIDTH-1:0] PULLUP = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  latch_q,
    input logic [WIDTH-1:0]  mask_q
);

    // R1
    reset_values_chk: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0) && (latch_q == '1) && (mask_q == '1));

    // R2
    dir_change_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(0) && bus_wdata != dir_q)
        |=> (dir_q == $past(bus_wdata)) && (mask_q == $past(latch_q)));

    // R3
    same_dir_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(0) && bus_wdata == dir_q)
        |=> $stable(dir_q) && $stable(mask_q));

    // R4
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(1))
        |=> (latch_q == $past(bus_wdata)) && $stable(mask_q));

    // R7
    pullup_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((PULLUP & ~dir_q & ~pin_out) == '0) && (((pin_out ^ latch_q) & dir_q) == '0));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr > ADDR_W'(1))
        |=> $stable(dir_q) && $stable(latch_q) && $stable(mask_q));

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |-> (bus_rdata == '0));

endmodule

bind bidir_io_port bidir_io_port_chk #(
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W),
    .PULLUP (PULLUP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .dir_q     (dir_q),
    .latch_q   (latch_q),
    .mask_q    (mask_q)
);

// File: tb/bidir_io_port_test.sv
// Directed bench for the bidirectional port; one task per scenario.
module bidir_io_port_test;

    localparam logic [7:0] PU = 8'h17;
    localparam logic [7:0] PD = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr_en = 1'b0;
    logic       bus_rd_en = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Model of the requirement-level state.
    logic [7:0] m_dir, m_latch, m_mask;

    always #10 clk = ~clk;

    bidir_io_port #(
        .WIDTH    (8),
        .ADDR_W   (2),
        .PULLUP   (PU),
        .PULLDOWN (PD)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out)
    );

    function automatic logic [7:0] exp_data(logic [7:0] pins);
        return ((pins & ~m_dir) | (m_mask & ~m_dir) | (m_latch & m_dir)) & ~(PD & ~m_dir);
    endfunction

    function automatic logic [7:0] exp_drive();
        return (m_latch & m_dir) | (PU & ~m_dir);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        if (a == 2'd0 && d != m_dir) begin
            m_mask = m_latch;
            m_dir  = d;
        end
        if (a == 2'd1) m_latch = d;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        #2;
        d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(2'd0, d); check("R1/R6 dir after reset", d, 8'h00);
        bus_read(2'd1, d); check("R1/R5 data after reset", d, 8'hDF);
        check("R1/R7 drive after reset", pin_out, 8'h17);
    endtask

    task automatic t_latch_write();
        logic [7:0] d;
        bus_write(2'd1, 8'h3C);
        check("R7 drive with all inputs", pin_out, exp_drive());
        bus_read(2'd1, d); check("R4 mask untouched by latch write", d, 8'hDF);
    endtask

    task automatic t_dir_change();
        logic [7:0] d;
        bus_write(2'd0, 8'hF0);
        bus_read(2'd0, d); check("R2/R6 dir loaded", d, 8'hF0);
        bus_read(2'd1, d); check("R2 mask captured latch", d, 8'h3C);
        check("R7 drive mixed", pin_out, 8'h37);
    endtask

    task automatic t_same_dir();
        logic [7:0] d;
        bus_write(2'd1, 8'hC3);
        bus_write(2'd0, 8'hF0);
        bus_read(2'd1, d); check("R3 equal dir write keeps mask", d, 8'hCC);
        check("R7 drive after latch change", pin_out, 8'hC7);
    endtask

    task automatic t_pins();
        logic [7:0] d;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'hFF);
        bus_write(2'd0, 8'h00);
        bus_read(2'd1, d); check("R5 cleared mask pins low", d, 8'h00);
        @(negedge clk);
        pin_in = 8'hFF;
        @(negedge clk); #2;
        bus_rd_en = 1'b1; bus_addr = 2'd1; #1;
        check("R8 pin not visible after one edge", bus_rdata, 8'h00);
        @(negedge clk); #2;
        check("R8/R5 pin visible after two edges, pulldown forced", bus_rdata, exp_data(8'hFF));
        bus_rd_en = 1'b0;
        bus_write(2'd1, 8'h20);
        bus_write(2'd0, 8'h20);
        bus_read(2'd1, d); check("R5 pulled-down bit as output reads latch", d, 8'hFF);
        check("R7 drive bit5 output", pin_out, exp_drive());
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, d); check("R9 dir unchanged by unmapped write", d, 8'h20);
        bus_read(2'd1, d); check("R9 data unchanged by unmapped write", d, exp_data(8'hFF));
        bus_read(2'd2, d); check("R9 unmapped read is zero", d, 8'h00);
        bus_read(2'd3, d); check("R9 unmapped read 3 is zero", d, 8'h00);
    endtask

    task automatic t_idle();
        @(negedge clk);
        bus_addr = 2'd0; bus_rd_en = 1'b0; #2;
        check("R10 no strobe, rdata zero", bus_rdata, 8'h00);
        bus_addr = 2'd1; #1;
        check("R10 no strobe on data offset", bus_rdata, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        m_dir = 8'h00; m_latch = 8'hFF; m_mask = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_write();
        t_dir_change();
        t_same_dir();
        t_pins();
        t_unmapped();
        t_idle();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule